// File: doc/BRIEF.md
# Paired-Compare PWM Timer Channel

This block is one channel of a general-purpose timer. A 16-bit up-counter advances on a prescaled tick while its run bit is set. Four compare registers, A to D, are checked against the counter on every tick. The registers are used in pairs to make pulse-width modulation: A and B steer output pin 0, and C and D steer output pin 1.

In each pair, the even register sets the duty edge and the odd register usually marks the period. Any compare register can be chosen as the counter-clear source through a coded select field. Each register carries a 4-bit I/O-control nibble that states what its match does to its pin. Pin drivers are enabled only in the PWM-pairing mode, and each pin has its own enable bit.

Software reaches all state through one write port with a 3-bit address. Address 0 holds control. Its fields are: [1:0] prescale, [6:4] clear select, [9:8] mode, and bit 12+p, which enables pin p. Address 1 holds the I/O-control bytes. Address 2 is the counter. Bit 0 of address 3 is the run bit. Addresses 4 to 7 are compare registers A to D. The counter value is visible at all times on `cnt_o`. Built with only two compare registers, the block offers one pin, and clear codes 5 and 6 select nothing.

Top module: `tmr_pwm_channel`

## Requirements
- R1: The 16-bit counter on `cnt_o` increases by one per count step, and it holds its value while the run bit (address 3, bit 0) is clear.
- R2: The prescale field (control [1:0]) values 0, 1, 2 and 3 give one count step every 1, 4, 16 and 64 clock cycles. With a divide of N, the first step lands N cycles after the clock edge that sets the run bit.
- R3: Clear select (control [6:4]) codes 1, 2, 5 and 6 pick register A, B, C or D. On a count step where the counter equals the picked register, the counter goes to 0 instead of incrementing.
- R4: With any other clear-select code, the counter runs freely and wraps from 0xFFFF to 0.
- R5: The I/O-control byte at address 1 [7:0] serves pin 0: its low nibble belongs to A and its high nibble to B. Bits [15:8] serve pin 1 in the same way, with C low and D high. On a register's match, the low two bits of its nibble act on the pin: 0 keeps the level, 1 drives low, 2 drives high and 3 toggles. Writing address 1 loads each pin with bit 2 of its even register's nibble.
- R6: A pair byte of 0x65 gives a switching output: high from the counter clear, low after the duty (even) register matches. A pair byte of 0x11 holds the pin low, and 0x66 holds it high.
- R7: When both registers of a pair match on the same step, the odd register's action wins. A duty value equal to the period value therefore causes no transition.
- R8: The mode field (control [9:8]) value 2 selects PWM pairing, and `pwm_oe[p]` then follows control bit 12+p. Any other mode value forces every `pwm_oe` bit low.
- R9: Writing the counter (address 2) loads the written value at that edge. The write overrides counting and clearing, and no compare actions take place in that cycle.
- R10: After reset the counter is 0, the pins are low, the enables are low and the channel is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| cnt_o | output | 16 | Current counter value |
| pwm_o | output | 2 | Pin levels (pin 0 from A/B, pin 1 from C/D) |
| pwm_oe | output | 2 | Pin output enables |

## Verification
Every register write takes effect at the clock edge where the strobe is sampled. A counter step changes `cnt_o` and any pin it affects at the very same edge, with no extra register stage between them. With a divide of N, the first step after a run-bit write arrives N edges later. The bench keeps a cycle model that advances on the same rising edges as the design. It compares all outputs at every falling edge, and its directed checks count edges from the write edge before sampling.

// File: rtl/tmr_pwm_pkg.sv
package tmr_pwm_pkg;

  localparam logic [2:0] ADR_CTRL = 3'd0;
  localparam logic [2:0] ADR_IOC  = 3'd1;
  localparam logic [2:0] ADR_CNT  = 3'd2;
  localparam logic [2:0] ADR_RUN  = 3'd3;
  localparam logic [2:0] ADR_GR0  = 3'd4;

  localparam logic [1:0] MODE_PWM1 = 2'd2;

  localparam logic [2:0] CLR_A = 3'd1;
  localparam logic [2:0] CLR_B = 3'd2;
  localparam logic [2:0] CLR_C = 3'd5;
  localparam logic [2:0] CLR_D = 3'd6;

  localparam int OE_LSB = 12;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } pin_act_e;

  typedef struct packed {
    logic [1:0] mode;
    logic [2:0] clr_sel;
    logic [1:0] presc;
  } ctrl_t;

  // cycles per count step minus one
  function automatic logic [5:0] presc_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd0;
      2'd1:    return 6'd3;
      2'd2:    return 6'd15;
      default: return 6'd63;
    endcase
  endfunction

  // one-hot choice of the clearing register, empty for unused codes
  function automatic logic [3:0] clr_mask(input logic [2:0] code, input int num_gr);
    case (code)
      CLR_A:   return 4'b0001;
      CLR_B:   return 4'b0010;
      CLR_C:   return (num_gr > 2) ? 4'b0100 : 4'b0000;
      CLR_D:   return (num_gr > 2) ? 4'b1000 : 4'b0000;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic apply_act(input logic cur, input logic [1:0] act);
    case (pin_act_e'(act))
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);

  localparam int DIV_W = 6;

  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] lim;

  assign lim  = presc_limit(sel);
  assign tick = run && (pre_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (!run)   pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  // R2: back-to-back steps only with divide-by-one
  a_r2_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $past(tick) && $past(run) && $stable(sel)) |-> (sel == 2'd0))
    else $error("R2 consecutive ticks with a divider above one");

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr_hit,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (wr)       cnt <= wdata;
    else if (tick) begin
      if (clr_hit)     cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  // R9: software load wins
  a_r9_cnt_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cnt == $past(wdata)))
    else $error("R9 counter write not loaded");

  // R3: clear on selected match
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clr_hit && !wr) |=> (cnt == '0))
    else $error("R3 counter not cleared");

  // R4: free-running wrap
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr_hit && !wr && (cnt == '1)) |=> (cnt == '0))
    else $error("R4 counter did not wrap");

endmodule

// File: rtl/tmr_compare.sv
module tmr_compare
  import tmr_pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_GR = 4
) (
  input  logic [CNT_W-1:0]             cnt,
  input  logic [NUM_GR-1:0][CNT_W-1:0] gr,
  input  logic                         tick,
  input  logic                         blk,
  input  logic [2:0]                   clr_sel,
  output logic [NUM_GR-1:0]            match,
  output logic                         clr_hit
);

  logic [3:0] sel_mask;

  assign sel_mask = clr_mask(clr_sel, NUM_GR);

  for (genvar g = 0; g < NUM_GR; g++) begin : g_cmp
    assign match[g] = tick && !blk && (cnt == gr[g]);
  end

  assign clr_hit = |(match & sel_mask[NUM_GR-1:0]);

endmodule

// File: rtl/tmr_pin_ctrl.sv
module tmr_pin_ctrl
  import tmr_pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] io_cfg,
  input  logic       io_wr,
  input  logic       io_init,
  input  logic       duty_hit,
  input  logic       per_hit,
  output logic       level
);

  logic after_duty;
  logic level_nxt;

  always_comb begin
    after_duty = duty_hit ? apply_act(level, io_cfg[1:0]) : level;
    level_nxt  = per_hit  ? apply_act(after_duty, io_cfg[5:4]) : after_duty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     level <= 1'b0;
    else if (io_wr) level <= io_init;
    else            level <= level_nxt;
  end

  // R6: constant encodings hold the pin
  a_r6_const_low: assert property (@(posedge clk) disable iff (!rst_n)
    (io_cfg == 8'h11) |-> !level)
    else $error("R6 pin left low setting");
  a_r6_const_high: assert property (@(posedge clk) disable iff (!rst_n)
    (io_cfg == 8'h66) |-> level)
    else $error("R6 pin left high setting");

  // R7: period register action wins on a shared step
  a_r7_period_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_hit && per_hit && !io_wr && (io_cfg[5:4] == 2'd2)) |=> level)
    else $error("R7 duty action overrode period action");

endmodule

// File: rtl/tmr_pwm_channel.sv
module tmr_pwm_channel
  import tmr_pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_GR = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [2:0]            wr_addr,
  input  logic [CNT_W-1:0]      wr_data,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [NUM_GR/2-1:0]   pwm_o,
  output logic [NUM_GR/2-1:0]   pwm_oe
);

  localparam int NPIN  = NUM_GR / 2;
  localparam int IOC_W = 8 * NPIN;

  ctrl_t                      ctrl_q;
  logic [NPIN-1:0]            oe_en_q;
  logic [IOC_W-1:0]           ioc_q;
  logic                       run_q;
  logic [NUM_GR-1:0][CNT_W-1:0] gr_q;

  logic              tick;
  logic              cnt_wr;
  logic              ioc_wr;
  logic [NUM_GR-1:0] match;
  logic              clr_hit;

  assign cnt_wr = wr_en && (wr_addr == ADR_CNT);
  assign ioc_wr = wr_en && (wr_addr == ADR_IOC);

  // control, I/O, run
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      oe_en_q <= '0;
      ioc_q   <= '0;
      run_q   <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CTRL: begin
          ctrl_q.presc   <= wr_data[1:0];
          ctrl_q.clr_sel <= wr_data[6:4];
          ctrl_q.mode    <= wr_data[9:8];
          oe_en_q        <= wr_data[OE_LSB +: NPIN];
        end
        ADR_IOC: ioc_q <= wr_data[IOC_W-1:0];
        ADR_RUN: run_q <= wr_data[0];
        default: ;
      endcase
    end
  end

  // compare registers
  for (genvar g = 0; g < NUM_GR; g++) begin : g_gr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        gr_q[g] <= '0;
      else if (wr_en && (wr_addr == 3'(ADR_GR0 + g)))
        gr_q[g] <= wr_data;
    end
  end

  tmr_prescaler u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_q),
    .sel  (ctrl_q.presc),
    .tick (tick)
  );

  tmr_compare #(.CNT_W(CNT_W), .NUM_GR(NUM_GR)) u_cmp (
    .cnt    (cnt_o),
    .gr     (gr_q),
    .tick   (tick),
    .blk    (cnt_wr),
    .clr_sel(ctrl_q.clr_sel),
    .match  (match),
    .clr_hit(clr_hit)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .clr_hit(clr_hit),
    .wr     (cnt_wr),
    .wdata  (wr_data),
    .cnt    (cnt_o)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    tmr_pin_ctrl u_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .io_cfg  (ioc_q[8*p +: 8]),
      .io_wr   (ioc_wr),
      .io_init (wr_data[8*p + 2]),
      .duty_hit(match[2*p]),
      .per_hit (match[2*p + 1]),
      .level   (pwm_o[p])
    );
    assign pwm_oe[p] = (ctrl_q.mode == MODE_PWM1) && oe_en_q[p];
  end

  // R1: stopped counter holds
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cnt_wr) |=> $stable(cnt_o))
    else $error("R1 counter moved while stopped");

  // R8: enables only in pairing mode
  a_r8_oe_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_oe != '0) |-> (ctrl_q.mode == MODE_PWM1))
    else $error("R8 enable outside pairing mode");

endmodule

// File: tb/tmr_pwm_channel_test.sv
module tmr_pwm_channel_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt_o;
  logic [1:0]  pwm_o;
  logic [1:0]  pwm_oe;

  always #10 clk = ~clk;

  tmr_pwm_channel uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_o(cnt_o), .pwm_o(pwm_o), .pwm_oe(pwm_oe)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    chk_en = 0;
  bit    done = 0;
  string cur_req = "R10";

  // reference state
  logic [15:0] m_cnt, m_ioc;
  logic [15:0] m_gr [4];
  int          m_pre;
  logic        m_run;
  logic [1:0]  m_ps, m_mode, m_oe, m_lvl;
  logic [2:0]  m_cs;
  bit          s_tick, s_cw, s_clr;
  logic [3:0]  s_hit;
  int          s_ci;

  function automatic int divisor(input logic [1:0] ps);
    return 1 << (2 * ps);
  endfunction

  function automatic int clr_idx(input logic [2:0] cs);
    if (cs == 3'd1) return 0;
    if (cs == 3'd2) return 1;
    if (cs == 3'd5) return 2;
    if (cs == 3'd6) return 3;
    return -1;
  endfunction

  function automatic logic act(input logic cur, input logic [1:0] a);
    if (a == 2'd1) return 1'b0;
    if (a == 2'd2) return 1'b1;
    if (a == 2'd3) return !cur;
    return cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_ioc = 0; m_pre = 0; m_run = 0; m_ps = 0; m_mode = 0;
      m_oe = 0; m_lvl = 0; m_cs = 0;
      for (int i = 0; i < 4; i++) m_gr[i] = 0;
    end else begin
      s_tick = m_run && (m_pre >= divisor(m_ps) - 1);
      s_cw   = wr_en && (wr_addr == 3'd2);
      for (int i = 0; i < 4; i++) s_hit[i] = s_tick && !s_cw && (m_cnt == m_gr[i]);
      s_ci  = clr_idx(m_cs);
      s_clr = (s_ci >= 0) && s_hit[s_ci];
      if (!m_run || s_tick) m_pre = 0; else m_pre = m_pre + 1;
      if (s_cw) m_cnt = wr_data;
      else if (s_tick) m_cnt = s_clr ? 16'd0 : m_cnt + 16'd1;
      for (int p = 0; p < 2; p++) begin
        if (wr_en && wr_addr == 3'd1) m_lvl[p] = wr_data[8*p+2];
        else begin
          if (s_hit[2*p])   m_lvl[p] = act(m_lvl[p], m_ioc[8*p +: 2]);
          if (s_hit[2*p+1]) m_lvl[p] = act(m_lvl[p], m_ioc[8*p+4 +: 2]);
        end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_ps = wr_data[1:0]; m_cs = wr_data[6:4];
                      m_mode = wr_data[9:8]; m_oe = wr_data[13:12]; end
          3'd1: m_ioc = wr_data;
          3'd3: m_run = wr_data[0];
          3'd4, 3'd5, 3'd6, 3'd7: m_gr[wr_addr - 3'd4] = wr_data;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act_v, exp_v, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_en && !done) begin
      chk(cur_req, {16'd0, cnt_o}, {16'd0, m_cnt});
      chk(cur_req, {30'd0, pwm_o}, {30'd0, m_lvl});
      chk("R8", {30'd0, pwm_oe}, {30'd0, (m_mode == 2'd2) ? m_oe : 2'b00});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_en = 1;
    // R10 reset state
    chk("R10", {16'd0, cnt_o}, 32'd0);
    chk("R10", {30'd0, pwm_o}, 32'd0);
    chk("R10", {30'd0, pwm_oe}, 32'd0);

    // R1 stopped counter stays
    cur_req = "R1";
    edges(5);
    chk("R1", {16'd0, cnt_o}, 32'd0);

    // R8 enables in pairing mode; R2 divide by 4
    wr(3'd0, 16'h3201);
    chk("R8", {30'd0, pwm_oe}, 32'd3);
    cur_req = "R2";
    wr(3'd3, 16'd1);
    edges(20);
    chk("R2", {16'd0, cnt_o}, 32'd5);
    wr(3'd3, 16'd0);
    held = cnt_o;
    edges(10);
    chk("R1", {16'd0, cnt_o}, {16'd0, held});

    // R4 wrap with no clear source
    cur_req = "R4";
    wr(3'd0, 16'h3200);
    wr(3'd2, 16'hFFFD);
    wr(3'd3, 16'd1);
    edges(3);
    chk("R4", {16'd0, cnt_o}, 32'd0);
    wr(3'd3, 16'd0);

    // R3 / R5 / R6 switching on pin 0, clear on B
    cur_req = "R6";
    wr(3'd5, 16'd9);
    wr(3'd4, 16'd3);
    wr(3'd0, 16'h3220);
    wr(3'd2, 16'd0);
    wr(3'd1, 16'h0065);
    chk("R5", {30'd0, pwm_o}, 32'd1);
    wr(3'd3, 16'd1);
    edges(3);
    chk("R6", {16'd0, cnt_o}, 32'd3);
    chk("R6", {30'd0, pwm_o}, 32'd1);
    edges(1);
    chk("R6", {30'd0, pwm_o}, 32'd0);
    edges(6);
    chk("R3", {16'd0, cnt_o}, 32'd0);
    chk("R6", {30'd0, pwm_o}, 32'd1);
    wr(3'd3, 16'd0);

    // R7 duty equal to period: no transition
    cur_req = "R7";
    wr(3'd4, 16'd9);
    wr(3'd2, 16'd0);
    wr(3'd1, 16'h0065);
    wr(3'd3, 16'd1);
    for (int i = 0; i < 25; i++) begin
      edges(1);
      chk("R7", {31'd0, pwm_o[0]}, 32'd1);
    end
    wr(3'd3, 16'd0);

    // R3 code 6 clears on D; R6 constant encodings
    cur_req = "R3";
    wr(3'd6, 16'd2);
    wr(3'd7, 16'd5);
    wr(3'd0, 16'h3260);
    wr(3'd2, 16'd0);
    wr(3'd1, 16'h1166);
    wr(3'd3, 16'd1);
    edges(6);
    chk("R3", {16'd0, cnt_o}, 32'd0);
    for (int i = 0; i < 20; i++) begin
      edges(1);
      chk("R6", {30'd0, pwm_o}, 32'd1);
    end

    // R9 counter write while running
    cur_req = "R9";
    wr(3'd2, 16'd40);
    chk("R9", {16'd0, cnt_o}, 32'd40);
    edges(1);
    chk("R9", {16'd0, cnt_o}, 32'd41);

    // R8 other modes drop enables
    wr(3'd0, 16'h3060);
    chk("R8", {30'd0, pwm_oe}, 32'd0);
    wr(3'd0, 16'h3360);
    chk("R8", {30'd0, pwm_oe}, 32'd0);
    wr(3'd3, 16'd0);

    // R5 toggle action
    cur_req = "R5";
    wr(3'd4, 16'd1);
    wr(3'd5, 16'd3);
    wr(3'd0, 16'h3220);
    wr(3'd2, 16'd0);
    wr(3'd1, 16'h0033);
    chk("R5", {31'd0, pwm_o[0]}, 32'd0);
    wr(3'd3, 16'd1);
    edges(2);
    chk("R5", {31'd0, pwm_o[0]}, 32'd1);
    edges(2);
    chk("R5", {31'd0, pwm_o[0]}, 32'd0);

    // random traffic against the model
    cur_req = "R3";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 7 == 0) begin
        logic [2:0]  a;
        logic [15:0] d;
        a = 3'($urandom % 8);
        d = 16'($urandom);
        if (a >= 3'd4 || a == 3'd2) d = 16'($urandom % 40);
        if (a == 3'd0 && ($urandom % 2 == 0)) d[9:8] = 2'd2;
        if (a == 3'd0 && ($urandom % 2 == 0)) d[1:0] = 2'd0;
        if (a == 3'd3 && ($urandom % 4 != 0)) d[0] = 1'b1;
        wr(a, d);
      end else begin
        edges(1);
      end
    end

    finish_run();
  end

endmodule